// File: doc/BRIEF.md
# CRC-Guarded Configuration Register

A single 32-bit register that software writes and reads over a simple strobe interface, with its contents protected by a 6-bit cyclic redundancy checksum. Whenever the register is written, a combinational generator divides the message bits, starting from a non-zero seed, and stores the remainder next to the data in the same clock edge. Whenever the register is read, a checker divides the stored message together with its stored checksum by the same polynomial. A non-zero remainder means the contents have been corrupted since the last write, and a registered error flag is raised.

Two storage layouts are selected by a parameter. In the field layout the upper six bits of the word carry the checksum and are visible to software, leaving 26 message bits. In the hidden layout all 32 bits are message and the checksum sits in six extra flops that software cannot see. A second parameter removes the checker and its flag entirely. A fault-injection mask input flips chosen stored bits without touching the checksum, so the detection path can be exercised in silicon.

Top module: `crc_guard_reg`

## Requirements
- R1: A write strobe stores the low message bits of the write data on the next clock edge, and read data always shows the current stored word bits 31:0.
- R2: In the field layout, message is bits 25:0, and after a write bits 31:26 of the read data hold the remainder of bits 25:0 under polynomial x^6+x^4+x^3+x (coefficients 6'b011010), divided MSB first from seed 6'b110111; write data bits 31:26 are ignored.
- R3: In the hidden layout, all 32 write bits are message and read back unchanged; the checksum is kept in stored bits 37:32 and never appears on read data.
- R4: Reset (active low, asynchronous) clears the message to zero, loads the checksum of an all-zero message, and clears the error flag.
- R5: A read strobe loads the error flag on the next edge with 1 exactly when the division of the stored message followed by the stored checksum leaves a non-zero remainder.
- R6: The error flag holds its value through idle cycles and writes until the next read strobe.
- R7: Bit i of the fault mask flips stored bit i (message from bit 0 upward, checksum directly above it) without recomputing the checksum; a write in the same cycle takes priority and the mask is then ignored.
- R8: Any single flipped stored bit, message or checksum, makes the next read raise the error flag.
- R9: With the checker excluded by parameter, the error output stays 0 whatever is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read strobe, samples the checker |
| rd_data_o | output | DATA_W | Current stored word |
| fault_mask_i | input | STORE_W | Stored-bit flip mask (32 field, 38 hidden) |
| err_o | output | 1 | Registered checksum error flag |

## Verification
On every cycle the assertions check that a written word is self-consistent under the checker, that the written message reaches the read data, that the error flag follows the checker's remainder on reads and is stable otherwise, that a single flip always breaks consistency, and that a build without the checker never flags. Only the bench scenarios show the actual checksum values against an independent long-division model, the reset value, detection of each of the 32 or 38 single-bit flips in turn, write priority over injection, and the behaviour of each layout and of the checker-less build side by side.

// File: rtl/crc_guard_pkg.sv
package crc_guard_pkg;

  localparam int unsigned BITS_MAX = 64;
  localparam int unsigned CRC_MAX  = 16;

  typedef enum logic {
    LAYOUT_FIELD  = 1'b0,
    LAYOUT_HIDDEN = 1'b1
  } layout_e;

  // MSB-first serial division over the low n bits, w-bit remainder
  function automatic logic [CRC_MAX-1:0] crc_fold(
    input logic [BITS_MAX-1:0] bits,
    input int unsigned         n,
    input int unsigned         w,
    input logic [CRC_MAX-1:0]  poly,
    input logic [CRC_MAX-1:0]  seed
  );
    logic [CRC_MAX-1:0] r;
    logic [CRC_MAX-1:0] mask;
    logic               fb;
    mask = (CRC_MAX'(1) << w) - CRC_MAX'(1);
    r    = seed & mask;
    for (int i = BITS_MAX - 1; i >= 0; i--) begin
      if (i < int'(n)) begin
        fb = r[w-1] ^ bits[i];
        r  = ((r << 1) ^ (fb ? poly : '0)) & mask;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/crc_unit.sv
module crc_unit #(
  parameter int unsigned N    = 26,
  parameter int unsigned W    = 6,
  parameter logic [W-1:0] POLY = 6'b011010,
  parameter logic [W-1:0] SEED = 6'b110111
) (
  input  logic [N-1:0] bits_i,
  output logic [W-1:0] rem_o
);
  import crc_guard_pkg::*;

  logic [CRC_MAX-1:0] full;

  always_comb begin
    full  = crc_fold(BITS_MAX'(bits_i), N, W, CRC_MAX'(POLY), CRC_MAX'(SEED));
    rem_o = full[W-1:0];
  end

endmodule

// File: rtl/crc_err_flag.sv
module crc_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_en_i,
  input  logic bad_i,
  output logic err_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_o <= 1'b0;
    else if (rd_en_i) err_o <= bad_i;
  end

endmodule

// File: rtl/crc_guard_reg.sv
module crc_guard_reg
  import crc_guard_pkg::*;
#(
  parameter int unsigned  DATA_W      = 32,
  parameter int unsigned  CRC_W       = 6,
  parameter logic [CRC_W-1:0] POLY    = 6'b011010,
  parameter logic [CRC_W-1:0] SEED    = 6'b110111,
  parameter layout_e      LAYOUT      = LAYOUT_FIELD,
  parameter bit           HAS_CHECKER = 1'b1,
  localparam int unsigned MSG_W   = (LAYOUT == LAYOUT_HIDDEN) ? DATA_W : DATA_W - CRC_W,
  localparam int unsigned STORE_W = MSG_W + CRC_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               rd_en_i,
  output logic [DATA_W-1:0]  rd_data_o,
  input  logic [STORE_W-1:0] fault_mask_i,
  output logic               err_o
);

  localparam logic [CRC_MAX-1:0] RST_FULL =
    crc_fold('0, MSG_W, CRC_W, CRC_MAX'(POLY), CRC_MAX'(SEED));
  localparam logic [STORE_W-1:0] RST_STORE = {RST_FULL[CRC_W-1:0], {MSG_W{1'b0}}};

  logic [STORE_W-1:0] store_q;
  logic [MSG_W-1:0]   wr_msg;
  logic [CRC_W-1:0]   wr_crc;
  logic               store_clean;

  assign wr_msg = wr_data_i[MSG_W-1:0];

  crc_unit #(.N(MSG_W), .W(CRC_W), .POLY(POLY), .SEED(SEED)) u_gen (
    .bits_i (wr_msg),
    .rem_o  (wr_crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              store_q <= RST_STORE;
    else if (wr_en_i)         store_q <= {wr_crc, wr_msg};
    else if (|fault_mask_i)   store_q <= store_q ^ fault_mask_i;
  end

  assign rd_data_o = store_q[DATA_W-1:0];

  generate
    if (LAYOUT == LAYOUT_FIELD) begin : g_field
      logic unused_wr_hi;
      assign unused_wr_hi = ^wr_data_i[DATA_W-1:MSG_W];
    end

    if (HAS_CHECKER) begin : g_chk
      logic [CRC_W-1:0] chk_rem;
      // message then stored checksum, divided in one pass
      crc_unit #(.N(STORE_W), .W(CRC_W), .POLY(POLY), .SEED(SEED)) u_chk_div (
        .bits_i ({store_q[MSG_W-1:0], store_q[STORE_W-1:MSG_W]}),
        .rem_o  (chk_rem)
      );
      assign store_clean = (chk_rem == '0);
      crc_err_flag u_flag (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .rd_en_i (rd_en_i),
        .bad_i   (!store_clean),
        .err_o   (err_o)
      );
    end else begin : g_nochk
      logic unused_rd;
      assign unused_rd   = rd_en_i;
      assign store_clean = 1'b1;
      assign err_o       = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/crc_guard_reg_chk.sv
module crc_guard_reg_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned MSG_W   = 26,
  parameter int unsigned STORE_W = 32,
  parameter bit          HAS_CHK = 1'b1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [DATA_W-1:0]  wr_data_i,
  input logic               rd_en_i,
  input logic [DATA_W-1:0]  rd_data_o,
  input logic [STORE_W-1:0] fault_mask_i,
  input logic               err_o,
  input logic               clean_i
);

  p_wr_msg_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[MSG_W-1:0] == $past(wr_data_i[MSG_W-1:0]));

  p_wr_clean_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HAS_CHK && wr_en_i) |=> clean_i);

  p_err_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HAS_CHK && rd_en_i) |=> (err_o == !$past(clean_i)));

  p_err_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(err_o));

  p_single_flip_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HAS_CHK && !wr_en_i && clean_i && $countones(fault_mask_i) == 1) |=> !clean_i);

  p_no_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !HAS_CHK |-> !err_o);

endmodule

bind crc_guard_reg crc_guard_reg_chk #(
  .DATA_W(DATA_W), .MSG_W(MSG_W), .STORE_W(STORE_W), .HAS_CHK(HAS_CHECKER)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_data_i    (wr_data_i),
  .rd_en_i      (rd_en_i),
  .rd_data_o    (rd_data_o),
  .fault_mask_i (fault_mask_i),
  .err_o        (err_o),
  .clean_i      (store_clean)
);

// File: tb/sim_crc_guard_reg.sv
`timescale 1ns/1ps
module sim_crc_guard_reg;
  import crc_guard_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] fm0 = '0, fm2 = '0;
  logic [37:0] fm1 = '0;
  logic [31:0] rd0, rd1, rd2;
  logic        err0, err1, err2;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  crc_guard_reg #(.LAYOUT(LAYOUT_FIELD), .HAS_CHECKER(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_data_o(rd0), .fault_mask_i(fm0), .err_o(err0));
  crc_guard_reg #(.LAYOUT(LAYOUT_HIDDEN), .HAS_CHECKER(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_data_o(rd1), .fault_mask_i(fm1), .err_o(err1));
  crc_guard_reg #(.LAYOUT(LAYOUT_FIELD), .HAS_CHECKER(1'b0)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_data_o(rd2), .fault_mask_i(fm2), .err_o(err2));

  // polynomial long division: (seed*x^n + msg*x^6) mod 1011010
  function automatic logic [5:0] ref_crc(input logic [31:0] msg, input int n);
    logic [63:0] a;
    a = (64'(6'b110111) << n) ^ (64'(msg) << 6);
    for (int b = 63; b >= 6; b--)
      if (a[b]) a = a ^ (64'h5A << (b - 6));
    return a[5:0];
  endfunction

  function automatic logic [31:0] field_word(input logic [31:0] d);
    return {ref_crc({6'b0, d[25:0]}, 26), d[25:0]};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    tick();
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read;
    @(negedge clk); rd_en = 1'b1;
    tick();
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic do_fault(input logic [37:0] m);
    @(negedge clk); fm0 = m[31:0]; fm1 = m; fm2 = m[31:0];
    tick();
    @(negedge clk); fm0 = '0; fm1 = '0; fm2 = '0;
  endtask

  task automatic clean_cycle(input logic [31:0] d, input string tag);
    do_write(d);
    check({tag, " R2 field word"}, 64'(rd0), 64'(field_word(d)));
    check({tag, " R3 hidden word"}, 64'(rd1), 64'(d));
    check({tag, " R1 msg"}, 64'(rd2[25:0]), 64'(d[25:0]));
    do_read();
    check({tag, " R5 clean field"}, 64'(err0), 64'd0);
    check({tag, " R5 clean hidden"}, 64'(err1), 64'd0);
  endtask

  initial begin : watchdog
    #(5ns * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] pat;
    repeat (3) @(posedge clk);
    #1;
    // R4 reset state
    check("R4 field reset", 64'(rd0), 64'({ref_crc(32'd0, 26), 26'd0}));
    check("R4 hidden reset", 64'(rd1), 64'd0);
    check("R4 err reset", 64'({err0, err1, err2}), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    do_read();
    check("R4 reset content clean", 64'({err0, err1}), 64'd0);

    // R1 R2 R3 R5 sweep of patterns
    clean_cycle(32'h0000_0000, "zero");
    clean_cycle(32'hFFFF_FFFF, "ones");
    clean_cycle(32'hA5A5_5A5A, "mix");
    for (int i = 0; i < 32; i++) clean_cycle(32'd1 << i, "walk1");
    for (int i = 0; i < 32; i++) clean_cycle(~(32'd1 << i), "walk0");

    // R8 R7 single flip of each stored bit, then R6 hold
    pat = 32'h1357_9BDF;
    for (int i = 0; i < 38; i++) begin
      do_write(pat);
      do_fault(38'd1 << i);
      if (i < 32) begin
        check("R7 field flip", 64'(rd0), 64'(field_word(pat) ^ (32'd1 << i)));
        check("R3 hidden flip", 64'(rd1), 64'(pat ^ (32'd1 << i)));
      end else begin
        check("R3 hidden crc invisible", 64'(rd1), 64'(pat));
      end
      do_read();
      check("R8 field detect", 64'(err0), (i < 32) ? 64'd1 : 64'd0);
      check("R8 hidden detect", 64'(err1), 64'd1);
      check("R9 no checker", 64'(err2), 64'd0);
      tick(); tick();
      check("R6 hold idle", 64'(err1), 64'd1);
      do_write(pat);
      check("R6 hold over write", 64'(err1), 64'd1);
      do_read();
      check("R6 cleared by read", 64'(err1), 64'd0);
    end

    // R7 write wins over fault in same cycle
    @(negedge clk); wr_en = 1'b1; wr_data = 32'hCAFE_0123; fm0 = 32'h8; fm1 = 38'h8;
    tick();
    @(negedge clk); wr_en = 1'b0; fm0 = '0; fm1 = '0;
    check("R7 write priority field", 64'(rd0), 64'(field_word(32'hCAFE_0123)));
    check("R7 write priority hidden", 64'(rd1), 64'(32'hCAFE_0123));
    do_read();
    check("R7 write priority err", 64'({err0, err1}), 64'd0);

    // R8 double flip on hidden checksum stays detected (non-zero remainder)
    do_fault(38'h3 << 32);
    do_read();
    check("R5 multi flip hidden", 64'(err1), 64'd1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule